// File: doc/BRIEF.md
# Key-Locked Control Register File

A bank of 32-bit control and status words on a simple word-addressed bus. The bus has separate write and read strobes, a byte address, write data and read data. The index of a word is the byte address shifted right by two. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.

A key word at index 0 gates writes to the lower part of the bank. Writing the magic value to the key stores 1 and opens the bank. Writing any other value stores 0 and closes it. While the key holds 0, writes to indices from 1 up to a boundary index are dropped. Writes at or above the boundary always land.

Some words are special:
- Identification and counter words are read-only.
- A strap word can gain ones through its own address. Its bits can only be cleared through the revision address, whose own value never changes.
- A random-data word returns a fresh word from a 32-bit LFSR on every read.

Every access is sorted into one of seven classes: key, strap-set, strap-clear, read-only, random, plain and out-of-range. A `unique case` on that class selects the action. The key behaves as a two-state lock, closed (key = 0) and open (key ≠ 0). A key write with the magic value moves it to open, and a key write with any other value moves it to closed. After reset it starts from the `key_init` port.

Top module: `kc_regfile`

## Requirements
- R1: A write to a plain word at byte address A stores the data at index A>>2. A read at A returns that word on `rdata` in the cycle after the read strobe. A read and a write in the same cycle return the value held before the write.
- R2: A write to the key (address 0x000) stores 1 when the data equals MAGIC (default 0x1688A8A8) and stores 0 otherwise. Reading address 0x000 returns the stored key. The key is writable whether the bank is open or closed.
- R3: While the key holds 0, writes to indices 1 to PROT_END-1 are dropped (default PROT_END = 65, byte address 0x104). This includes the strap and revision addresses. Writes at index PROT_END or above still take effect.
- R4: A write to the strap word (0x070) ORs the data into it. A write of zero leaves it unchanged.
- R5: A write to the revision address (0x07C) clears the strap bits where the data has ones. The revision word keeps its reset value.
- R6: Writes to the read-only addresses are ignored. These are 0x014, 0x050 to 0x06C, 0x078, 0x0E0, 0x0E4, 0x150 and 0x154.
- R7: Each read of 0x078 advances the LFSR once and returns the new state. The LFSR state after reset is LFSR_SEED (default 0xACE12468). The step is next = (s>>1) XOR (s[0] ? 0x80200003 : 0). The state is never zero.
- R8: A read at index NUM_REGS or above (default 128, byte address 0x200 and up) returns 0. A write there changes no word.
- R9: Reset loads the following values, and every other word resets to 0:

  | Address | Reset value |
  |---|---|
  | 0x004 | 0xFFC00F0F |
  | 0x008 | 0x00001234 |
  | 0x040 | 0x000000C0 |
  | 0x0E0 | 0x000000FF |
  | 0x0E4 | 0x000000FF |
  | 0x150 | CHIP_ID_LO (default 0xC0DE0001) |
  | 0x154 | CHIP_ID_HI (default 0xC0DE0002) |
  | 0x000 (key) | `key_init` |
  | 0x07C (revision) | `silrev_init` |
  | 0x070 (strap 1) | `strap1_init` |
  | 0x0D0 (strap 2) | `strap2_init` |

  `rdata` resets to 0.
- R10: `rdata` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| key_init | input | 32 | Key value loaded at reset |
| silrev_init | input | 32 | Revision word loaded at reset |
| strap1_init | input | 32 | Strap word loaded at reset |
| strap2_init | input | 32 | Second strap word loaded at reset |
| rdata | output | 32 | Registered read data |

## Verification
The lock is tried with the key starting at 0, then with a wrong value, the magic value and a relock. Each setting is followed by writes on both sides of the boundary (0x100 against 0x104), which tells a range check that is off by one from a correct one. The strap is driven with overlapping set and clear patterns and with zero data, which separates OR, overwrite and clear behaviour. Every read-only address is written with all ones. Repeated random reads expose a missing or double LFSR step. Out-of-range accesses at 0x200 and 0xFFC are followed by reads of low words, which reveals any index aliasing.

// File: rtl/kc_pkg.sv
`timescale 1ns/1ps
package kc_pkg;
    typedef enum logic [2:0] {
        ACC_KEY,
        ACC_STRAP_SET,
        ACC_STRAP_CLR,
        ACC_RO,
        ACC_RNG,
        ACC_PLAIN,
        ACC_OOR
    } acc_e;

    localparam int IX_KEY    = 0;
    localparam int IX_STRAP1 = 28;
    localparam int IX_RNG    = 30;
    localparam int IX_SILREV = 31;
    localparam int IX_STRAP2 = 52;
    localparam int IX_CHIP0  = 84;
    localparam int IX_CHIP1  = 85;

    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
    endfunction

    function automatic logic is_ro(input int i);
        return (i == 5) || (i >= 20 && i <= 27) || (i == 56) || (i == 57)
            || (i == IX_CHIP0) || (i == IX_CHIP1);
    endfunction

    function automatic logic [31:0] rst_value(input int i);
        case (i)
            1:       return 32'hFFC0_0F0F;
            2:       return 32'h0000_1234;
            16:      return 32'h0000_00C0;
            56, 57:  return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/kc_decode.sv
`timescale 1ns/1ps
module kc_decode
    import kc_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int NUM_REGS = 128,
    parameter int PROT_END = 65
) (
    input  logic [IDX_W-1:0] idx,
    output acc_e             cls,
    output logic             in_prot
);
    logic [31:0] ix32;

    always_comb begin
        ix32    = 32'(idx);
        in_prot = (ix32 > 32'(IX_KEY)) && (ix32 < 32'(PROT_END));
        if (ix32 >= 32'(NUM_REGS))        cls = ACC_OOR;
        else if (ix32 == 32'(IX_KEY))     cls = ACC_KEY;
        else if (ix32 == 32'(IX_STRAP1))  cls = ACC_STRAP_SET;
        else if (ix32 == 32'(IX_SILREV))  cls = ACC_STRAP_CLR;
        else if (ix32 == 32'(IX_RNG))     cls = ACC_RNG;
        else if (is_ro(int'(ix32)))       cls = ACC_RO;
        else                              cls = ACC_PLAIN;
    end
endmodule

// File: rtl/kc_keygate.sv
`timescale 1ns/1ps
module kc_keygate #(
    parameter logic [31:0] MAGIC = 32'h1688_A8A8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_key,
    input  logic [31:0] wdata,
    input  logic [31:0] key_init,
    output logic [31:0] key_q,
    output logic        unlocked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      key_q <= key_init;
        else if (wr_key) key_q <= {31'd0, (wdata == MAGIC)};
    end

    assign unlocked = (key_q != 32'd0);

    p_key_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_key |=> (key_q == {31'd0, ($past(wdata) == MAGIC)}));
endmodule

// File: rtl/kc_lfsr.sv
`timescale 1ns/1ps
module kc_lfsr
    import kc_pkg::*;
#(
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [31:0] nxt
);
    logic [31:0] state_q;

    assign nxt = lfsr_step(state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SEED;
        else if (adv) state_q <= nxt;
    end

    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'd0);
    p_lfsr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (state_q != $past(state_q)));
endmodule

// File: rtl/kc_regfile.sv
`timescale 1ns/1ps
module kc_regfile
    import kc_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_REGS   = 128,
    parameter int          PROT_END   = 65,
    parameter logic [31:0] MAGIC      = 32'h1688_A8A8,
    parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468,
    parameter logic [31:0] CHIP_ID_LO = 32'hC0DE_0001,
    parameter logic [31:0] CHIP_ID_HI = 32'hC0DE_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       key_init,
    input  logic [31:0]       silrev_init,
    input  logic [31:0]       strap1_init,
    input  logic [31:0]       strap2_init,
    output logic [31:0]       rdata
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int REG_IW = $clog2(NUM_REGS);

    logic [IDX_W-1:0]  idx;
    logic [REG_IW-1:0] ix;
    acc_e              cls;
    logic              in_prot;
    logic [31:0]       key_q;
    logic              unlocked;
    logic              wr_allow;
    logic [31:0]       rng_nxt;
    logic [31:0]       regs [NUM_REGS];

    assign idx      = addr[ADDR_W-1:2];
    assign ix       = idx[REG_IW-1:0];
    assign wr_allow = unlocked || !in_prot;

    kc_decode #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .PROT_END(PROT_END)) u_dec (
        .idx(idx), .cls(cls), .in_prot(in_prot)
    );

    kc_keygate #(.MAGIC(MAGIC)) u_key (
        .clk(clk), .rst_n(rst_n),
        .wr_key(wr_en && (cls == ACC_KEY)),
        .wdata(wdata), .key_init(key_init),
        .key_q(key_q), .unlocked(unlocked)
    );

    kc_lfsr #(.SEED(LFSR_SEED)) u_rng (
        .clk(clk), .rst_n(rst_n),
        .adv(rd_en && (cls == ACC_RNG)),
        .nxt(rng_nxt)
    );

    // Storage update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_value(i);
            regs[IX_SILREV] <= silrev_init;
            regs[IX_STRAP1] <= strap1_init;
            regs[IX_STRAP2] <= strap2_init;
            regs[IX_CHIP0]  <= CHIP_ID_LO;
            regs[IX_CHIP1]  <= CHIP_ID_HI;
        end else if (wr_en && wr_allow) begin
            unique case (cls)
                ACC_STRAP_SET: regs[IX_STRAP1] <= regs[IX_STRAP1] | wdata;
                ACC_STRAP_CLR: regs[IX_STRAP1] <= regs[IX_STRAP1] & ~wdata;
                ACC_PLAIN:     regs[ix] <= wdata;
                default:       ;
            endcase
        end
    end

    // Registered read path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= 32'd0;
        end else if (rd_en) begin
            unique case (cls)
                ACC_OOR: rdata <= 32'd0;
                ACC_KEY: rdata <= key_q;
                ACC_RNG: rdata <= rng_nxt;
                default: rdata <= regs[ix];
            endcase
        end
    end

    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cls == ACC_OOR) |=> (rdata == 32'd0));
    p_strap_only_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_allow && cls == ACC_STRAP_CLR)
        |=> ((regs[IX_STRAP1] & $past(regs[IX_STRAP1])) == $past(regs[IX_STRAP1])));
    p_silrev_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(regs[IX_SILREV]));
    p_chip_id_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($stable(regs[IX_CHIP0]) && $stable(regs[IX_CHIP1])));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_kc_regfile.sv
`timescale 1ns/1ps
module sim_kc_regfile;
    localparam logic [31:0] MAGIC = 32'h1688_A8A8;
    localparam logic [31:0] SEED  = 32'hACE1_2468;
    localparam logic [31:0] K_SIL = 32'h0403_0303;
    localparam logic [31:0] K_S1  = 32'h0000_0A05;
    localparam logic [31:0] K_S2  = 32'h1111_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int    checks = 0;
    int    fails = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_tag = "R9";

    kc_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .key_init(32'd0),
        .silrev_init(K_SIL), .strap1_init(K_S1), .strap2_init(K_S2),
        .rdata(rdata)
    );

    always #10 clk = ~clk;

    // Reference model
    logic [31:0] m_regs [0:127];
    logic [31:0] m_key, m_lfsr, m_rdata;
    string       m_tag = "R9";
    int          mi;

    function automatic logic [31:0] m_step(input logic [31:0] s);
        if (s[0]) return (s >> 1) ^ 32'h8020_0003;
        return s >> 1;
    endfunction

    function automatic bit m_ro(input int i);
        return i == 5 || (i >= 20 && i <= 27) || i == 56 || i == 57 || i == 84 || i == 85;
    endfunction

    always @(posedge clk) begin
        mi = int'(addr) / 4;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_regs[i] = 32'd0;
            m_regs[1] = 32'hFFC0_0F0F;  m_regs[2] = 32'h0000_1234;
            m_regs[16] = 32'h0000_00C0; m_regs[56] = 32'h0000_00FF;
            m_regs[57] = 32'h0000_00FF; m_regs[84] = 32'hC0DE_0001;
            m_regs[85] = 32'hC0DE_0002; m_regs[31] = K_SIL;
            m_regs[28] = K_S1;          m_regs[52] = K_S2;
            m_key = 32'd0; m_lfsr = SEED; m_rdata = 32'd0;
        end else begin
            m_tag = cur_tag;
            if (rd_en) begin
                if (mi >= 128) m_rdata = 32'd0;
                else if (mi == 0) m_rdata = m_key;
                else if (mi == 30) begin m_lfsr = m_step(m_lfsr); m_rdata = m_lfsr; end
                else m_rdata = m_regs[mi];
            end
            if (wr_en && mi < 128) begin
                if (mi == 0) m_key = (wdata == MAGIC) ? 32'd1 : 32'd0;
                else if (m_key == 32'd0 && mi < 65) ;
                else if (mi == 28) m_regs[28] = m_regs[28] | wdata;
                else if (mi == 31) m_regs[28] = m_regs[28] & ~wdata;
                else if (m_ro(mi) || mi == 30) ;
                else m_regs[mi] = wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && armed) begin
            checks++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s addr=%h rdata=%h expected=%h", m_tag, addr, rdata, m_rdata);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string t);
        @(negedge clk);
        cur_tag = t; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [11:0] a, input string t);
        @(negedge clk);
        cur_tag = t; wr_en = 1'b0; rd_en = 1'b1; addr = a;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_tag = "R10"; wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        // R9 reset values
        rd(12'h000, "R9"); rd(12'h004, "R9"); rd(12'h008, "R9"); rd(12'h040, "R9");
        rd(12'h070, "R9"); rd(12'h07C, "R9"); rd(12'h0D0, "R9"); rd(12'h0E0, "R9");
        rd(12'h0E4, "R9"); rd(12'h150, "R9"); rd(12'h154, "R9"); rd(12'h104, "R9");
        // R3 closed bank
        wr(12'h004, 32'hDEAD_BEEF, "R3"); rd(12'h004, "R3");
        wr(12'h070, 32'hF000_0000, "R3"); rd(12'h070, "R3");
        wr(12'h07C, 32'h0000_0005, "R3"); rd(12'h070, "R3");
        wr(12'h100, 32'h1111_2222, "R3"); rd(12'h100, "R3");
        wr(12'h104, 32'h3333_4444, "R3"); rd(12'h104, "R3");
        wr(12'h0D0, 32'h5555_6666, "R3"); rd(12'h0D0, "R3");
        // R2 key
        wr(12'h000, 32'h0000_1234, "R2"); rd(12'h000, "R2");
        wr(12'h000, MAGIC, "R2"); rd(12'h000, "R2");
        // R1 plain words
        wr(12'h004, 32'hA5A5_0001, "R1"); wr(12'h044, 32'h0BAD_F00D, "R1");
        wr(12'h100, 32'h7777_8888, "R1");
        rd(12'h004, "R1"); rd(12'h044, "R1"); rd(12'h100, "R1");
        @(negedge clk); cur_tag = "R1"; wr_en = 1'b1; rd_en = 1'b1; addr = 12'h044; wdata = 32'h1234_5678;
        rd(12'h044, "R1");
        // R4 strap set
        wr(12'h070, 32'h00F0_0000, "R4"); rd(12'h070, "R4");
        wr(12'h070, 32'h0000_0000, "R4"); rd(12'h070, "R4");
        wr(12'h070, 32'h00FF_0A00, "R4"); rd(12'h070, "R4");
        // R5 strap clear via revision
        wr(12'h07C, 32'h0030_0005, "R5"); rd(12'h070, "R5"); rd(12'h07C, "R5");
        // R6 read-only words
        wr(12'h014, 32'hFFFF_FFFF, "R6"); rd(12'h014, "R6");
        for (int a = 12'h050; a <= 12'h06C; a += 4) begin
            wr(12'(a), 32'hFFFF_FFFF, "R6"); rd(12'(a), "R6");
        end
        wr(12'h0E0, 32'hFFFF_FFFF, "R6"); rd(12'h0E0, "R6");
        wr(12'h0E4, 32'hFFFF_FFFF, "R6"); rd(12'h0E4, "R6");
        wr(12'h150, 32'hFFFF_FFFF, "R6"); rd(12'h150, "R6");
        wr(12'h154, 32'hFFFF_FFFF, "R6"); rd(12'h154, "R6");
        // R7 random words
        rd(12'h078, "R7"); rd(12'h078, "R7"); idle(1);
        rd(12'h078, "R7"); rd(12'h078, "R7");
        wr(12'h078, 32'h0000_0000, "R7"); rd(12'h078, "R7");
        // R2 relock and R3 again
        wr(12'h000, MAGIC + 32'd1, "R2"); rd(12'h000, "R2");
        wr(12'h004, 32'h0000_0000, "R3"); rd(12'h004, "R3");
        wr(12'h07C, 32'hFFFF_FFFF, "R3"); rd(12'h070, "R3");
        // R8 out of range
        wr(12'h200, 32'hCAFE_CAFE, "R8"); wr(12'hFFC, 32'hCAFE_CAFE, "R8");
        rd(12'h200, "R8"); rd(12'hFFC, "R8"); rd(12'h000, "R8"); rd(12'h004, "R8");
        rd(12'h104, "R8");
        // R10 hold
        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule